// File: doc/BRIEF.md
# Privileged Exception and Interrupt Dispatcher

This block decides, on a take strobe, whether the core enters privileged code, and computes where it enters. A synchronous exception reported by the pipeline is always taken. With no such exception, the block looks at four interrupt lines: device, timer, inter-processor and machine check. It masks them against the current priority level and picks the most urgent one that remains. No interrupt is taken while the core already runs in privileged mode.

On a dispatch the block does four things. It forms the new program counter from the privileged-code base plus a vector offset. It saves the interrupted PC with the old mode in bit 0. It raises the privileged-mode flag and records the error code. A memory fault also loads three trap-argument registers: the faulting address, the fault code, and the access cause.

All results are registered. They appear one cycle after the strobe, together with a one-cycle `dispatch_o` pulse.

Top module: `exc_dispatch`

## Requirements
- R1: Reset clears every output to zero. A dispatch is decided at the clock edge where `take_i` is high, and its results and a one-cycle `dispatch_o` pulse appear on the next cycle. Without `take_i` there is no dispatch, and `new_pc_o`, `exc_addr_o`, `err_code_o` and the trap arguments hold their values.
- R2: When `take_i` and `sync_valid_i` are both high with a defined kind, the synchronous exception is dispatched, even if interrupts are pending and eligible.
- R3: With `priv_i` high and no synchronous exception, no interrupt is dispatched.
- R4: The priority level `ipl_i` masks the interrupt lines as follows. Device is eligible only at levels 0 to 3. Timer is eligible at levels 0 to 4. Inter-processor is eligible at levels 0 to 5. Machine check is eligible at levels 0 to 6. Nothing is eligible at level 7.
- R5: Among the eligible pending lines, the winner is chosen in this order: machine check, then inter-processor, then timer, then device.
- R6: The kind encoding and the vector offsets are fixed. Kind 0 is reset at 0x000. Kind 1 is machine check at 0x080. Kind 2 is inter-processor at 0x100. Kind 3 is timer at 0x180. Kind 4 is device at 0x200. Kind 5 is memory fault at 0x280. Kind 6 is unaligned at 0x300. Kind 7 is illegal opcode at 0x380. Kind 8 is arithmetic at 0x400. Kind 9 is FP-disabled at 0x480. An interrupt uses the offset of its own kind.
- R7: Kind 10 is a call gate with an 8-bit code n. If bit 7 of n is set, the offset is 0x2000 + (n − 0x80)·64. If bit 7 is clear, the offset is 0x1000 + n·64.
- R8: On a dispatch, `exc_addr_o` is `pc_i` with bit 0 replaced by `priv_i`.
- R9: On a dispatch, `new_pc_o` is `pal_base_i` plus the offset and `mode_o` is 1. On every other cycle, `mode_o` is `priv_i` from the previous cycle.
- R10: A memory-fault dispatch records three trap arguments. `trap0_o` gets `fault_addr_i`. `trap1_o` gets the zero-extended `fault_code_i`. `trap2_o` gets the cause, which depends on `access_i`: 0 (load) gives 0, 1 (store) gives 1, and 2 or 3 (fetch) gives all ones. Any other dispatch leaves the trap arguments unchanged.
- R11: `err_code_o` takes `sync_code_i` on a synchronous dispatch and is cleared to 0 on an interrupt dispatch.
- R12: A synchronous exception with a reserved kind (11 to 15) causes no dispatch in that cycle, not even of a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take-exception strobe |
| sync_valid_i | input | 1 | A synchronous exception is present |
| sync_kind_i | input | 4 | Exception kind (R6, R7) |
| sync_code_i | input | 8 | Error code / call-gate number |
| fault_addr_i | input | XLEN | Faulting address |
| fault_code_i | input | 8 | Memory fault code |
| access_i | input | 2 | Faulting access type |
| irq_dev_i | input | 1 | Device interrupt pending |
| irq_tmr_i | input | 1 | Timer interrupt pending |
| irq_ipi_i | input | 1 | Inter-processor interrupt pending |
| irq_mchk_i | input | 1 | Machine check pending |
| pc_i | input | XLEN | Current PC |
| pal_base_i | input | XLEN | Privileged-code base |
| ipl_i | input | 3 | Current priority level |
| priv_i | input | 1 | Current privileged-mode flag |
| dispatch_o | output | 1 | One-cycle dispatch pulse |
| new_pc_o | output | XLEN | Entry address |
| exc_addr_o | output | XLEN | Saved exception address |
| mode_o | output | 1 | Privileged-mode flag |
| err_code_o | output | 8 | Recorded error code |
| trap0_o | output | XLEN | Trap argument 0 |
| trap1_o | output | XLEN | Trap argument 1 |
| trap2_o | output | XLEN | Trap argument 2 |

## Verification
Every result lies one register away from the strobe. The bench drives inputs and raises `take_i` on a falling edge, and the rising edge that follows captures the dispatch. At the next falling edge the bench drops the strobe and samples all outputs, so each check lands on the first cycle the result is due. The cases that must not dispatch are reserved kinds, privileged mode, and fully masked levels. For these the bench samples at the same point and compares `new_pc_o` and `dispatch_o` with their previous values.

// File: rtl/exc_dispatch.sv
module exc_dispatch #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            sync_valid_i,
  input  logic [3:0]      sync_kind_i,
  input  logic [7:0]      sync_code_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic [7:0]      fault_code_i,
  input  logic [1:0]      access_i,
  input  logic            irq_dev_i,
  input  logic            irq_tmr_i,
  input  logic            irq_ipi_i,
  input  logic            irq_mchk_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] pal_base_i,
  input  logic [2:0]      ipl_i,
  input  logic            priv_i,
  output logic            dispatch_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] exc_addr_o,
  output logic            mode_o,
  output logic [7:0]      err_code_o,
  output logic [XLEN-1:0] trap0_o,
  output logic [XLEN-1:0] trap1_o,
  output logic [XLEN-1:0] trap2_o
);

  localparam logic [3:0] K_MCHK  = 4'd1;
  localparam logic [3:0] K_IPI   = 4'd2;
  localparam logic [3:0] K_TMR   = 4'd3;
  localparam logic [3:0] K_DEV   = 4'd4;
  localparam logic [3:0] K_MFLT  = 4'd5;
  localparam logic [3:0] K_GATE  = 4'd10;
  localparam int         OFF_W   = 16;

  logic mchk_ok, ipi_ok, tmr_ok, dev_ok, irq_any;
  logic sync_ok, go_sync, go_irq, go;
  logic [3:0] irq_kind, sel_kind;
  logic [OFF_W-1:0] gate_off, vec_off;
  logic [XLEN-1:0] cause;

  assign mchk_ok = irq_mchk_i && (ipl_i <= 3'd6);
  assign ipi_ok  = irq_ipi_i  && (ipl_i <= 3'd5);
  assign tmr_ok  = irq_tmr_i  && (ipl_i <= 3'd4);
  assign dev_ok  = irq_dev_i  && (ipl_i <= 3'd3);
  assign irq_any = !priv_i && (mchk_ok || ipi_ok || tmr_ok || dev_ok);

  assign irq_kind = mchk_ok ? K_MCHK :
                    ipi_ok  ? K_IPI  :
                    tmr_ok  ? K_TMR  : K_DEV;

  assign sync_ok = sync_valid_i && (sync_kind_i <= K_GATE);
  assign go_sync = take_i && sync_ok;
  assign go_irq  = take_i && !sync_valid_i && irq_any;
  assign go      = go_sync || go_irq;

  assign sel_kind = go_sync ? sync_kind_i : irq_kind;

  assign gate_off = (sync_code_i[7] ? 16'h2000 : 16'h1000)
                  + {3'd0, sync_code_i[6:0], 6'd0};
  assign vec_off  = (sel_kind == K_GATE) ? gate_off : {5'd0, sel_kind, 7'd0};

  always_comb begin
    case (access_i)
      2'd0:    cause = '0;
      2'd1:    cause = XLEN'(1);
      default: cause = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dispatch_o <= 1'b0;
      new_pc_o   <= '0;
      exc_addr_o <= '0;
      mode_o     <= 1'b0;
      err_code_o <= '0;
      trap0_o    <= '0;
      trap1_o    <= '0;
      trap2_o    <= '0;
    end else begin
      dispatch_o <= go;
      mode_o     <= go ? 1'b1 : priv_i;
      if (go) begin
        new_pc_o   <= pal_base_i + XLEN'(vec_off);
        exc_addr_o <= {pc_i[XLEN-1:1], priv_i};
        err_code_o <= go_sync ? sync_code_i : 8'd0;
        if (go_sync && sync_kind_i == K_MFLT) begin
          trap0_o <= fault_addr_i;
          trap1_o <= XLEN'(fault_code_i);
          trap2_o <= cause;
        end
      end
    end
  end

  // R1
  no_take_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> !dispatch_o);

  // R3
  priv_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !sync_valid_i && priv_i) |=> !dispatch_o);

  // R4
  ipl7_masks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !sync_valid_i && ipl_i == 3'd7) |=> !dispatch_o);

  // R8
  saved_mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && (sync_valid_i || !priv_i)) |=> (!dispatch_o || exc_addr_o[0] == $past(priv_i)));

  // R9
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_o |-> mode_o);

  // R10
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && sync_valid_i && sync_kind_i != K_MFLT) |=> $stable(trap0_o) && $stable(trap2_o));

  // R11
  irq_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !sync_valid_i) |=> (err_code_o == 8'd0 || !dispatch_o));

  // R12
  reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && sync_valid_i && sync_kind_i > K_GATE) |=> !dispatch_o);

endmodule

// File: tb/exc_dispatch_bench.sv
module exc_dispatch_bench;
  localparam int XLEN = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take_i = 0, sync_valid_i = 0;
  logic [3:0] sync_kind_i = 0;
  logic [7:0] sync_code_i = 0, fault_code_i = 0;
  logic [XLEN-1:0] fault_addr_i = 0, pc_i = 0, pal_base_i = 0;
  logic [1:0] access_i = 0;
  logic irq_dev_i = 0, irq_tmr_i = 0, irq_ipi_i = 0, irq_mchk_i = 0;
  logic [2:0] ipl_i = 0;
  logic priv_i = 0;
  logic dispatch_o, mode_o;
  logic [XLEN-1:0] new_pc_o, exc_addr_o, trap0_o, trap1_o, trap2_o;
  logic [7:0] err_code_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_dispatch #(.XLEN(XLEN)) u_exc_dispatch (
    .clk, .rst_n, .take_i, .sync_valid_i, .sync_kind_i, .sync_code_i,
    .fault_addr_i, .fault_code_i, .access_i, .irq_dev_i, .irq_tmr_i,
    .irq_ipi_i, .irq_mchk_i, .pc_i, .pal_base_i, .ipl_i, .priv_i,
    .dispatch_o, .new_pc_o, .exc_addr_o, .mode_o, .err_code_o,
    .trap0_o, .trap1_o, .trap2_o);

  task automatic chk(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] vec(int k);
    case (k)
      0: return 64'h000; 1: return 64'h080; 2: return 64'h100; 3: return 64'h180;
      4: return 64'h200; 5: return 64'h280; 6: return 64'h300; 7: return 64'h380;
      8: return 64'h400; 9: return 64'h480; default: return 64'h0;
    endcase
  endfunction

  task automatic fire();
    take_i = 1;
    @(negedge clk);
    take_i = 0;
  endtask

  task automatic quiet();
    sync_valid_i = 0; irq_dev_i = 0; irq_tmr_i = 0; irq_ipi_i = 0; irq_mchk_i = 0;
    priv_i = 0; ipl_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset dispatch", XLEN'(dispatch_o), 0);
    chk("R1 reset pc", new_pc_o, 0);
    chk("R1 reset mode", XLEN'(mode_o), 0);
    chk("R1 reset trap0", trap0_o, 0);
  endtask

  task automatic t_vectors();
    pal_base_i = 64'h0000_0000_0010_0000;
    for (int k = 0; k < 10; k++) begin
      quiet(); sync_valid_i = 1; sync_kind_i = 4'(k); sync_code_i = 8'(k + 3);
      pc_i = 64'h4000 + 64'(k * 16);
      fire();
      chk($sformatf("R6 vector kind %0d", k), new_pc_o, pal_base_i + vec(k));
      chk("R9 dispatch pulse", XLEN'(dispatch_o), 1);
      chk("R11 sync err", XLEN'(err_code_o), XLEN'(k + 3));
    end
    @(negedge clk);
    chk("R1 pulse one cycle", XLEN'(dispatch_o), 0);
  endtask

  task automatic t_gate();
    logic [7:0] codes [4] = '{8'h00, 8'h3f, 8'h80, 8'hbf};
    logic [XLEN-1:0] exp;
    for (int i = 0; i < 4; i++) begin
      quiet(); sync_valid_i = 1; sync_kind_i = 4'd10; sync_code_i = codes[i];
      fire();
      exp = codes[i][7] ? 64'h2000 + (64'(codes[i]) - 64'h80) * 64 : 64'h1000 + 64'(codes[i]) * 64;
      chk($sformatf("R7 gate %h", codes[i]), new_pc_o, pal_base_i + exp);
    end
  endtask

  task automatic t_exc_addr();
    quiet(); priv_i = 1; sync_valid_i = 1; sync_kind_i = 4'd6; pc_i = 64'hABCD_0000_1234_5678;
    fire();
    chk("R8 exc addr priv", exc_addr_o, 64'hABCD_0000_1234_5679);
    chk("R9 mode set", XLEN'(mode_o), 1);
    quiet(); pc_i = 64'h0000_0000_0000_1001;
    sync_valid_i = 1; sync_kind_i = 4'd7;
    fire();
    chk("R8 exc addr user", exc_addr_o, 64'h1000);
    quiet();
    @(negedge clk);
    chk("R9 mode follows priv", XLEN'(mode_o), 0);
  endtask

  task automatic t_memfault();
    logic [XLEN-1:0] exp [4] = '{64'h0, 64'h1, '1, '1};
    for (int a = 0; a < 4; a++) begin
      quiet(); sync_valid_i = 1; sync_kind_i = 4'd5; access_i = 2'(a);
      fault_addr_i = 64'hFFFF_0000_0000_0100 + 64'(a); fault_code_i = 8'(a + 1);
      fire();
      chk($sformatf("R10 trap0 acc %0d", a), trap0_o, 64'hFFFF_0000_0000_0100 + 64'(a));
      chk("R10 trap1", trap1_o, 64'(a + 1));
      chk("R10 trap2", trap2_o, exp[a]);
    end
    quiet(); sync_valid_i = 1; sync_kind_i = 4'd8; fault_addr_i = 64'h55;
    fire();
    chk("R10 trap0 held", trap0_o, 64'hFFFF_0000_0000_0103);
    chk("R10 trap2 held", trap2_o, '1);
  endtask

  task automatic t_priority();
    quiet(); irq_dev_i = 1; irq_tmr_i = 1; irq_ipi_i = 1; irq_mchk_i = 1; sync_code_i = 8'h77;
    fire();
    chk("R5 mchk wins", new_pc_o, pal_base_i + vec(1));
    chk("R11 irq err cleared", XLEN'(err_code_o), 0);
    irq_mchk_i = 0; fire();
    chk("R5 ipi next", new_pc_o, pal_base_i + vec(2));
    irq_ipi_i = 0; fire();
    chk("R5 timer next", new_pc_o, pal_base_i + vec(3));
    irq_tmr_i = 0; fire();
    chk("R5 device last", new_pc_o, pal_base_i + vec(4));
  endtask

  task automatic t_mask();
    logic [XLEN-1:0] prev;
    quiet(); irq_dev_i = 1; irq_tmr_i = 1; ipl_i = 3'd4;
    fire(); chk("R4 ipl4 timer", new_pc_o, pal_base_i + vec(3));
    irq_tmr_i = 0; irq_ipi_i = 1; ipl_i = 3'd5;
    fire(); chk("R4 ipl5 ipi", new_pc_o, pal_base_i + vec(2));
    irq_mchk_i = 1; irq_ipi_i = 1; ipl_i = 3'd6; irq_mchk_i = 0;
    prev = new_pc_o;
    fire(); chk("R4 ipl6 ipi masked", XLEN'(dispatch_o), 0);
    chk("R4 ipl6 pc held", new_pc_o, prev);
    irq_mchk_i = 1;
    fire(); chk("R4 ipl6 mchk", new_pc_o, pal_base_i + vec(1));
    ipl_i = 3'd7; irq_dev_i = 1; irq_tmr_i = 1;
    fire(); chk("R4 ipl7 none", XLEN'(dispatch_o), 0);
  endtask

  task automatic t_priv_and_prec();
    logic [XLEN-1:0] prev;
    quiet(); irq_mchk_i = 1; priv_i = 1; prev = new_pc_o;
    fire();
    chk("R3 priv blocks irq", XLEN'(dispatch_o), 0);
    chk("R3 pc held", new_pc_o, prev);
    quiet(); irq_mchk_i = 1; sync_valid_i = 1; sync_kind_i = 4'd9; sync_code_i = 8'h21;
    fire();
    chk("R2 sync wins", new_pc_o, pal_base_i + vec(9));
    chk("R2 sync err", XLEN'(err_code_o), 64'h21);
    prev = new_pc_o;
    quiet(); irq_mchk_i = 1; sync_valid_i = 1; sync_kind_i = 4'd13;
    fire();
    chk("R12 reserved no dispatch", XLEN'(dispatch_o), 0);
    chk("R12 pc held", new_pc_o, prev);
    quiet(); irq_mchk_i = 1; sync_valid_i = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 no take no dispatch", XLEN'(dispatch_o), 0);
    chk("R1 no take pc held", new_pc_o, prev);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          failures++; checks++;
          $display("FAIL R1 watchdog got=hang exp=finish");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_vectors();
    t_gate();
    t_exc_addr();
    t_memfault();
    t_priority();
    t_mask();
    t_priv_and_prec();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule